// File: doc/BRIEF.md
# Gamma Channel Refresh Sequencer

This block paces the refresh of twelve analog sample-and-hold gamma channels. On every refresh tick it selects the next channel in a fixed rotation. It presents that channel's index, its 10-bit conversion code and the channel's ladder tap numerator, and it pulses a one-cycle sample strobe. It also reports whether the channel should follow its programmed code or the fixed reference-ladder level.

The refresh tick comes from one of two sources, chosen by a mode input. The first is an internal divider that, at the default setting, yields about 100 kHz from a 250 MHz system clock. The second is an external clock pin, which is synchronised and edge-detected inside the block.

Source selection follows the control pin. A separate override word forces register-driven levels when it holds one exact key value, whatever the level of the pin.

Top module: `gamma_refresh_seq`

## Requirements
- R1: After reset `ch_idx_o` is 0 and `strobe_o` is 0. No strobe appears until the first refresh tick arrives.
- R2: Each refresh tick produces one strobe. Channels are served in the order 0, 1, … 11 and then wrap to 0, so each channel is refreshed once per twelve ticks.
- R3: With each strobe, `code_o` equals the 10-bit slice `codes_i[10*k +: 10]` of the channel k shown on `ch_idx_o`.
- R4: `strobe_o` is high for exactly one system clock per tick.
- R5: In internal mode (`ext_mode_i` = 0) strobes are spaced exactly `DIV_CYC` system clocks apart. The default of 2500 gives 100 kHz at 250 MHz.
- R6: In external mode (`ext_mode_i` = 1) each rising edge of `ext_clk_i` yields exactly one strobe, and the internal divider produces none. With `ext_clk_i` held still, no strobe appears.
- R7: When `ctl_pin_i` is 0 and `ovr_code_i` is not 0x2A0, `use_reg_o` is 0 on the strobe. In every case `tap_o` equals 12 − k, the numerator over 13 of channel k's ladder level.
- R8: When `ctl_pin_i` is 1, `use_reg_o` is 1 on the strobe.
- R9: When `ovr_code_i` equals exactly 0x2A0, `use_reg_o` is 1 whatever `ctl_pin_i` is. Any other value, including 0x2A1 and 0x0A0, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| codes_i | input | 120 | Twelve 10-bit channel codes; channel k occupies bits 10k+9:10k |
| ovr_code_i | input | 10 | Override word; 0x2A0 forces register-driven levels |
| ext_mode_i | input | 1 | 0: internal divider tick, 1: external clock tick |
| ext_clk_i | input | 1 | External refresh clock, asynchronous |
| ctl_pin_i | input | 1 | Control pin; 1 selects register levels |
| ch_idx_o | output | 4 | Channel being sampled |
| code_o | output | 10 | Code of that channel |
| tap_o | output | 4 | Ladder tap numerator (over 13) for that channel |
| use_reg_o | output | 1 | 1: channel follows its code, 0: ladder level |
| strobe_o | output | 1 | One-cycle sample strobe |

## Verification
Several properties are checked by assertions on every cycle:
- the divider counter stays in range;
- each strobe leaves the rotation pointer one step past the channel it shows;
- the tap numerator tracks the index;
- strobes carry register selection whenever the pin or the key was present at the tick.

Other behaviours can only be shown by the bench's scenarios:
- the exact spacing of strobes in internal mode;
- the one-strobe-per-edge relation in external mode;
- the silence before the first tick;
- the rejection of near-miss override values.

// File: rtl/gamma_seq_pkg.sv
package gamma_seq_pkg;
  localparam logic [9:0] OVR_KEY = 10'h2A0;
  typedef enum logic {SRC_LADDER = 1'b0, SRC_REG = 1'b1} src_e;
endpackage

// File: rtl/gamma_tick_gen.sv
module gamma_tick_gen #(
  parameter int DIV_CYC = 2500,
  localparam int CNT_W = (DIV_CYC > 2) ? $clog2(DIV_CYC) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_mode_i,
  input  logic ext_clk_i,
  output logic tick_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             int_tick_q;
  logic [2:0]       sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      int_tick_q <= 1'b0;
    end else if (cnt_q == CNT_W'(DIV_CYC - 1)) begin
      cnt_q      <= '0;
      int_tick_q <= 1'b1;
    end else begin
      cnt_q      <= cnt_q + 1'b1;
      int_tick_q <= 1'b0;
    end
  end

  // two-flop synchroniser plus a history flop for edge detect
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[1:0], ext_clk_i};
  end

  assign tick_o = ext_mode_i ? (sync_q[1] & ~sync_q[2]) : int_tick_q;

  // R5
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DIV_CYC - 1));
  // R5
  int_tick_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_tick_q |-> cnt_q == '0);
endmodule

// File: rtl/gamma_src_sel.sv
module gamma_src_sel
  import gamma_seq_pkg::*;
#(
  parameter int CODE_W = 10
) (
  input  logic [CODE_W-1:0] ovr_code_i,
  input  logic              ctl_pin_i,
  output src_e              src_o
);
  logic key_hit;
  assign key_hit = (ovr_code_i == CODE_W'(OVR_KEY));
  assign src_o   = (key_hit || ctl_pin_i) ? SRC_REG : SRC_LADDER;
endmodule

// File: rtl/gamma_chan_seq.sv
module gamma_chan_seq
  import gamma_seq_pkg::*;
#(
  parameter int N_CH   = 12,
  parameter int CODE_W = 10,
  localparam int IDX_W = $clog2(N_CH),
  localparam int TAP_W = $clog2(N_CH + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   tick_i,
  input  logic [N_CH*CODE_W-1:0] codes_i,
  input  src_e                   src_i,
  output logic [IDX_W-1:0]       ch_idx_o,
  output logic [CODE_W-1:0]      code_o,
  output logic [TAP_W-1:0]       tap_o,
  output logic                   use_reg_o,
  output logic                   strobe_o
);
  logic [IDX_W-1:0] ptr_q;
  logic [IDX_W-1:0] ptr_nxt;

  assign ptr_nxt = (ptr_q == IDX_W'(N_CH - 1)) ? '0 : ptr_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q     <= '0;
      ch_idx_o  <= '0;
      code_o    <= '0;
      tap_o     <= '0;
      use_reg_o <= 1'b0;
      strobe_o  <= 1'b0;
    end else begin
      strobe_o <= tick_i;
      if (tick_i) begin
        ptr_q     <= ptr_nxt;
        ch_idx_o  <= ptr_q;
        code_o    <= codes_i[ptr_q*CODE_W +: CODE_W];
        tap_o     <= TAP_W'(N_CH) - TAP_W'(ptr_q);
        use_reg_o <= (src_i == SRC_REG);
      end
    end
  end

  // R2
  ptr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |-> ptr_q == ((ch_idx_o == IDX_W'(N_CH - 1)) ? '0 : ch_idx_o + 1'b1));
  // R2
  idx_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ch_idx_o < IDX_W'(N_CH));
endmodule

// File: rtl/gamma_refresh_seq.sv
module gamma_refresh_seq
  import gamma_seq_pkg::*;
#(
  parameter int N_CH    = 12,
  parameter int CODE_W  = 10,
  parameter int DIV_CYC = 2500,
  localparam int IDX_W  = $clog2(N_CH),
  localparam int TAP_W  = $clog2(N_CH + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_CH*CODE_W-1:0] codes_i,
  input  logic [CODE_W-1:0]      ovr_code_i,
  input  logic                   ext_mode_i,
  input  logic                   ext_clk_i,
  input  logic                   ctl_pin_i,
  output logic [IDX_W-1:0]       ch_idx_o,
  output logic [CODE_W-1:0]      code_o,
  output logic [TAP_W-1:0]       tap_o,
  output logic                   use_reg_o,
  output logic                   strobe_o
);
  logic tick;
  src_e src;

  gamma_tick_gen #(.DIV_CYC(DIV_CYC)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .ext_mode_i(ext_mode_i),
    .ext_clk_i(ext_clk_i), .tick_o(tick)
  );

  gamma_src_sel #(.CODE_W(CODE_W)) u_src (
    .ovr_code_i(ovr_code_i), .ctl_pin_i(ctl_pin_i), .src_o(src)
  );

  gamma_chan_seq #(.N_CH(N_CH), .CODE_W(CODE_W)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .codes_i(codes_i),
    .src_i(src), .ch_idx_o(ch_idx_o), .code_o(code_o), .tap_o(tap_o),
    .use_reg_o(use_reg_o), .strobe_o(strobe_o)
  );

  // R7
  tap_track_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |-> tap_o == TAP_W'(N_CH) - TAP_W'(ch_idx_o));
  // R9
  key_force_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && ovr_code_i == CODE_W'(OVR_KEY)) |=> use_reg_o);
  // R8
  pin_force_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && ctl_pin_i) |=> use_reg_o);
  // R4
  strobe_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(strobe_o) |-> $past(tick));
endmodule

// File: tb/gamma_refresh_seq_bench.sv
module gamma_refresh_seq_bench;
  localparam int N_CH = 12;
  localparam int CW   = 10;
  localparam int DIV  = 6;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic [N_CH*CW-1:0] codes_i = '0;
  logic [CW-1:0]   ovr_code_i = '0;
  logic            ext_mode_i = 1'b1;
  logic            ext_clk_i = 1'b0;
  logic            ctl_pin_i = 1'b0;
  logic [3:0]      ch_idx_o;
  logic [CW-1:0]   code_o;
  logic [3:0]      tap_o;
  logic            use_reg_o;
  logic            strobe_o;

  gamma_refresh_seq #(.N_CH(N_CH), .CODE_W(CW), .DIV_CYC(DIV)) u_gamma_refresh_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .codes_i(codes_i), .ovr_code_i(ovr_code_i),
    .ext_mode_i(ext_mode_i), .ext_clk_i(ext_clk_i), .ctl_pin_i(ctl_pin_i),
    .ch_idx_o(ch_idx_o), .code_o(code_o), .tap_o(tap_o),
    .use_reg_o(use_reg_o), .strobe_o(strobe_o)
  );

  always #2 clk_i = ~clk_i;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int n_strobe = 0;
  int exp_ptr = 0;
  logic prev_strobe = 1'b0;
  logic [N_CH*CW-1:0] snap_codes;
  logic [CW-1:0] snap_ovr;
  logic snap_pin;

  function automatic logic exp_use_reg(logic pin, logic [CW-1:0] ovr);
    return pin || (ovr == 10'h2A0);
  endfunction

  task automatic chk(string req, logic ok, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    snap_codes <= codes_i;
    snap_ovr   <= ovr_code_i;
    snap_pin   <= ctl_pin_i;
  end

  // monitor: inputs seen at the strobe-producing edge are in the snapshot
  always @(negedge clk_i) begin
    if (rst_ni && strobe_o) begin
      logic er;
      er = exp_use_reg(snap_pin, snap_ovr);
      chk("R2", int'(ch_idx_o) == exp_ptr, ch_idx_o, exp_ptr);
      chk("R3", code_o == snap_codes[exp_ptr*CW +: CW], code_o, snap_codes[exp_ptr*CW +: CW]);
      chk("R7", int'(tap_o) == 12 - exp_ptr, tap_o, 12 - exp_ptr);
      if (snap_ovr == 10'h2A0)  chk("R9", use_reg_o == er, use_reg_o, er);
      else if (snap_pin)        chk("R8", use_reg_o == er, use_reg_o, er);
      else                      chk("R7", use_reg_o == er, use_reg_o, er);
      chk("R4", !prev_strobe, prev_strobe, 0);
      exp_ptr  = (exp_ptr == N_CH - 1) ? 0 : exp_ptr + 1;
      n_strobe = n_strobe + 1;
    end
    prev_strobe = strobe_o;
  end

  task automatic wait_cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic set_inputs(logic pin, logic [CW-1:0] ovr);
    @(negedge clk_i);
    for (int k = 0; k < N_CH; k++) codes_i[k*CW +: CW] = CW'($urandom);
    ctl_pin_i  = pin;
    ovr_code_i = ovr;
  endtask

  task automatic run_ext(int edges);
    int n0;
    @(negedge clk_i);
    ext_mode_i = 1'b1;
    ext_clk_i  = 1'b0;
    wait_cyc(5);
    n0 = n_strobe;
    for (int e = 0; e < edges; e++) begin
      ext_clk_i = 1'b1;
      wait_cyc(3 + int'($urandom_range(3)));
      ext_clk_i = 1'b0;
      wait_cyc(3 + int'($urandom_range(3)));
    end
    wait_cyc(5);
    chk("R6", n_strobe - n0 == edges, n_strobe - n0, edges);
    n0 = n_strobe;
    wait_cyc(4 * DIV);
    chk("R6", n_strobe == n0, n_strobe - n0, 0);
  endtask

  task automatic run_int(int count);
    int last, cur, s;
    @(negedge clk_i);
    ext_mode_i = 1'b0;
    s = n_strobe;
    while (n_strobe == s) @(negedge clk_i);
    last = cyc;
    for (int i = 0; i < count; i++) begin
      s = n_strobe;
      while (n_strobe == s) @(negedge clk_i);
      cur = cyc;
      chk("R5", cur - last == DIV, cur - last, DIV);
      last = cur;
    end
    @(negedge clk_i);
    ext_mode_i = 1'b1;
  endtask

  initial begin
    void'($urandom(32'd1234));
    wait_cyc(3);
    rst_ni = 1'b1;
    wait_cyc(1);
    // R1: reset state, and no strobe while the external pin is idle
    chk("R1", ch_idx_o == 4'd0 && !strobe_o, {ch_idx_o, strobe_o}, 0);
    wait_cyc(40);
    chk("R1", n_strobe == 0, n_strobe, 0);

    set_inputs(1'b0, 10'h000); run_ext(13);   // R7 ladder, R2 wrap
    set_inputs(1'b1, 10'h000); run_int(12);   // R8
    set_inputs(1'b0, 10'h2A0); run_ext(12);   // R9 override
    set_inputs(1'b0, 10'h2A1); run_int(12);   // R9 near miss
    set_inputs(1'b0, 10'h0A0); run_ext(6);    // R9 near miss
    set_inputs(1'b1, 10'h2A0); run_int(6);
    for (int r = 0; r < 10; r++) begin
      logic [CW-1:0] o;
      o = ($urandom_range(2) == 0) ? 10'h2A0 : CW'($urandom);
      set_inputs(1'($urandom), o);
      if (r % 2 == 0) run_ext(3 + int'($urandom_range(15)));
      else            run_int(3 + int'($urandom_range(15)));
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule